// File: doc/BRIEF.md
# Power-On Time-Out Divider with Resynchronized Taps

This block is a free-running binary divider driven by the on-chip oscillator, which appears here as the clock input. After reset it counts oscillator cycles. It raises a single one-cycle time-out pulse once the configured delay has elapsed. The delay is four times longer when the device boots as a bus master, which stretches a nominal 16 ms wait at 8 MHz to about 64 ms.

Four bits of the divider are picked off as slow clocks at bit positions 4, 9, 14 and 19. Each bit passes through a retiming flop on the oscillator clock. Two output ports can each pick any one of the four retimed bits through its own 2-bit select. The raw oscillator is also made available on an output, but only while the oscillator-run enable bit is set.

Top module: `osc_tap_divider`

## Requirements
- R1: While `rst_n` is low, `tap_a`, `tap_b` and `timeout_pulse` are 0 and the divider count is held at zero.
- R2: The divider counts oscillator rising edges from zero, starting at reset release. Its taps are count bits 4, 9, 14 and 19 (the `TAP_POS` default).
- R3: Each tap passes through one retiming flop. After the k-th rising edge following reset release (k ≥ 1), a tap output shows bit p of the value k-1.
- R4: Select encoding, for `sel_a` and `sel_b` independently: 0 chooses bit 4, 1 chooses bit 9, 2 chooses bit 14 and 3 chooses bit 19. Both outputs may choose the same tap. A select change reaches its output in the same cycle.
- R5: `osc_out` is equal to `clk` while `osc_run_en` is 1, and it is held at 0 while `osc_run_en` is 0.
- R6: With `boot_master` low, `timeout_pulse` is high for exactly one cycle, starting after the `BASE_CYCLES`-th rising edge that follows reset release.
- R7: With `boot_master` high, the pulse comes after 4×`BASE_CYCLES` edges instead.
- R8: `boot_master` is sampled on the first edge after reset release. Later changes to it have no effect, and only one pulse occurs for each reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_master | input | 1 | High selects the long (×4) time-out |
| sel_a | input | 2 | Tap select for `tap_a` |
| sel_b | input | 2 | Tap select for `tap_b` |
| osc_run_en | input | 1 | Lets the oscillator through to `osc_out` |
| osc_out | output | 1 | Gated oscillator |
| tap_a | output | 1 | Retimed tap chosen by `sel_a` |
| tap_b | output | 1 | Retimed tap chosen by `sel_b` |
| timeout_pulse | output | 1 | One-cycle end-of-time-out pulse |

## Verification
The bench samples taps on the edge just before and just after each bit transition at positions 4, 9 and 14. A design with no retiming flop, or with a second one, would then show the transition one cycle early or one cycle late. The bench also steps through every select code on both outputs, so a swapped mux encoding would show the wrong bit. It runs the time-out in both modes and changes `boot_master` partway through each run. A design that sampled the mode continuously would fire early, fire late or fire twice, and a counter that did not saturate would produce a repeated pulse.

// File: rtl/osc_tap_divider.sv
module osc_tap_divider #(
  parameter int unsigned DIV_W       = 20,
  parameter int unsigned TAP_POS [4] = '{4, 9, 14, 19},
  parameter int unsigned BASE_CYCLES = 128000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_master,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  input  logic       osc_run_en,
  output logic       osc_out,
  output logic       tap_a,
  output logic       tap_b,
  output logic       timeout_pulse
);

  localparam int unsigned LONG_CYCLES = 4 * BASE_CYCLES;
  localparam int unsigned TW          = $clog2(LONG_CYCLES + 2);

  logic [DIV_W-1:0] div;
  logic [3:0]       tsync;
  logic [TW-1:0]    tcnt;
  logic             mode_q;
  logic [TW-1:0]    limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;

  for (genvar i = 0; i < 4; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tsync[i] <= 1'b0;
      else        tsync[i] <= div[TAP_POS[i]];

    assert_tap_retimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tsync[i] == $past(div[TAP_POS[i]]));
  end

  assign tap_a   = tsync[sel_a];
  assign tap_b   = tsync[sel_b];
  assign osc_out = clk & osc_run_en;

  assign limit = mode_q ? TW'(LONG_CYCLES) : TW'(BASE_CYCLES);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcnt   <= '0;
      mode_q <= 1'b0;
    end else begin
      if (tcnt == '0) mode_q <= boot_master;
      if (tcnt <= limit) tcnt <= tcnt + 1'b1;
    end

  assign timeout_pulse = (tcnt == limit);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt != '0) |=> $stable(mode_q));

  assert_pulse_on_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (div == DIV_W'(limit)));

endmodule

// File: tb/osc_tap_divider_test.sv
`timescale 1ns/1ps
module osc_tap_divider_test;
  localparam int BASE = 40;

  logic clk = 1'b0, rst_n = 1'b0, boot_master = 1'b0, osc_run_en = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
  logic osc_out, tap_a, tap_b, timeout_pulse;

  osc_tap_divider #(.BASE_CYCLES(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .boot_master(boot_master), .sel_a(sel_a), .sel_b(sel_b),
    .osc_run_en(osc_run_en), .osc_out(osc_out), .tap_a(tap_a), .tap_b(tap_b),
    .timeout_pulse(timeout_pulse));

  always #2.5 clk = ~clk;

  // {edge count, sel_a, sel_b, run enable}
  localparam int NV = 17;
  localparam logic [36:0] VEC [NV] = '{
    {32'd1, 2'd0, 2'd1, 1'b1}, {32'd15, 2'd0, 2'd0, 1'b0}, {32'd16, 2'd0, 2'd3, 1'b1},
    {32'd17, 2'd0, 2'd1, 1'b1}, {32'd31, 2'd0, 2'd2, 1'b1}, {32'd32, 2'd0, 2'd0, 1'b0},
    {32'd33, 2'd0, 2'd1, 1'b1}, {32'd512, 2'd1, 2'd0, 1'b1}, {32'd513, 2'd1, 2'd1, 1'b1},
    {32'd514, 2'd1, 2'd3, 1'b0}, {32'd1024, 2'd1, 2'd0, 1'b1}, {32'd1025, 2'd1, 2'd1, 1'b1},
    {32'd16384, 2'd2, 2'd2, 1'b1}, {32'd16385, 2'd2, 2'd0, 1'b1}, {32'd16386, 2'd3, 2'd2, 1'b1},
    {32'd32769, 2'd2, 2'd3, 1'b1}, {32'd40000, 2'd3, 2'd1, 1'b0}};

  int nchk = 0, nfail = 0, k = 0, pulses = 0, pulse_at = -1;
  bit finished = 0;

  function automatic logic model_tap(int edges, logic [1:0] s);
    int pos;
    pos = (s == 0) ? 4 : (s == 1) ? 9 : (s == 2) ? 14 : 19;
    return (edges == 0) ? 1'b0 : 1'((edges - 1) >> pos);
  endfunction

  task automatic check(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at edge %0d: got %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    k++;
    #1;
    if (timeout_pulse === 1'b1) begin
      pulses++;
      pulse_at = k;
    end
  endtask

  task automatic do_reset(logic master);
    @(negedge clk);
    rst_n = 1'b0;
    boot_master = master;
    #1;
    check("R1 tap_a in reset", tap_a, 1'b0);
    check("R1 tap_b in reset", tap_b, 1'b0);
    check("R1 pulse in reset", timeout_pulse, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    pulses = 0;
    pulse_at = -1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R2 R3 R4 R5: table walk
    for (int v = 0; v < NV; v++) begin
      while (k < int'(VEC[v][36:5])) step();
      sel_a = VEC[v][4:3];
      sel_b = VEC[v][2:1];
      osc_run_en = VEC[v][0];
      #0.5;
      check("R3/R4 tap_a", tap_a, model_tap(k, sel_a));
      check("R3/R4 tap_b", tap_b, model_tap(k, sel_b));
      check("R5 osc_out high phase", osc_out, osc_run_en);
      @(negedge clk);
      #0.5;
      check("R5 osc_out low phase", osc_out, 1'b0);
    end
    // R2: bit 19 has not toggled yet at edge 40000
    sel_a = 2'd3;
    #0.1;
    check("R2 bit19 still low", tap_a, 1'b0);
    // R6: one pulse at BASE in the long run
    check_int("R6 pulse count short", pulses, 1);
    check_int("R6 pulse edge short", pulse_at, BASE);

    // R7 R8: master mode, flag dropped mid-run
    do_reset(1'b1);
    while (k < 10) step();
    @(negedge clk);
    boot_master = 1'b0;
    while (k < 4 * BASE + 30) step();
    check_int("R7 pulse count long", pulses, 1);
    check_int("R7 pulse edge long", pulse_at, 4 * BASE);

    // R8: short mode, flag raised after the pulse
    do_reset(1'b0);
    while (k < BASE + 5) step();
    @(negedge clk);
    boot_master = 1'b1;
    while (k < 4 * BASE + 30) step();
    check_int("R8 single pulse", pulses, 1);
    check_int("R8 pulse edge", pulse_at, BASE);

    // R1: reset mid-run clears taps
    while (k < 600) step();
    do_reset(1'b0);
    step();
    sel_a = 2'd1;
    sel_b = 2'd0;
    #0.1;
    check("R1 tap_a after reset", tap_a, 1'b0);
    check("R1 tap_b after reset", tap_b, 1'b0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule